// File: doc/BRIEF.md
# JTAG-to-Wishbone Memory Access Bridge

This block sits behind a JTAG TAP controller and lets a debugger read and write system memory one 64-bit word at a time. The TAP supplies its decoded strobes (capture, shift, update), the serial data line and the current 4-bit instruction code, all in the TCK domain. Three instruction codes select the bridge. One selects a 29-bit address register. The other two select a 64-bit data register, which works either as a pure reader or as a swap that returns the old word while it stores the new one. On the system clock side the block is a Wishbone classic master.

Every access moves the word address on by one, so a run of data scans walks through memory without reloading the address. The bridge keeps a read-ahead word. Loading an address, and finishing every data access, starts a read of the location that the next data scan will return. Capture-DR then loads that word into the shift register. Each Update-DR raises one request that crosses to the system clock by a toggle handshake, so every update produces exactly one bus access sequence.

Top module: `jwb_bridge`

## Requirements
- R1: Only instruction codes 4'd5, 4'd6 and 4'd7 act on the bridge. A capture/shift/update sequence under any other code starts no bus cycle and leaves the address unchanged.
- R2: Under code 4'd5 the scan is 29 bits long and least significant bit first. Capture loads the current address, which then appears on tdo. Update-DR loads the shifted-in value as the new address.
- R3: An address update starts exactly one read cycle at the new address. It starts no write.
- R4: Under code 4'd6 a 64-bit scan shifts out, LSB first, the word stored at the current address. The bits shifted in are discarded. The update writes nothing, advances the address by one and reads the new address.
- R5: Under code 4'd7 a 64-bit scan shifts out the word previously held at the current address. The update writes the shifted-in word there with all eight byte selects set, then reads the next address.
- R6: Each data update (4'd6 or 4'd7) increments the 29-bit address by one and wraps from all ones to zero. Back-to-back data scans therefore reach consecutive words.
- R7: wb_cyc and wb_stb are asserted together. While no acknowledge has arrived, the address, write enable and write data stay stable and the cycle stays open.
- R8: Each Update-DR under a bridge code produces exactly one access sequence: one write then one read for 4'd7, one read otherwise.
- R9: After reset there is no bus cycle, tdo is 0 and the address register reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, system domain |
| tck | input | 1 | JTAG test clock |
| tck_rst | input | 1 | Synchronous active-high reset, TCK domain |
| ir | input | 4 | Instruction code currently selected by the TAP |
| capture_dr | input | 1 | Capture-DR state strobe |
| shift_dr | input | 1 | Shift-DR state strobe |
| update_dr | input | 1 | Update-DR state strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| wb_cyc | output | 1 | Bus cycle valid |
| wb_stb | output | 1 | Bus strobe |
| wb_we | output | 1 | Bus write enable |
| wb_adr | output | 29 | Bus word address |
| wb_dat_o | output | 64 | Bus write data |
| wb_sel | output | 8 | Byte selects |
| wb_dat_i | input | 64 | Bus read data |
| wb_ack | input | 1 | Bus acknowledge |

## Verification
Under the swap instruction, two events share one system clock edge: the acknowledge that closes the write phase, and the switch of the same bus cycle to a read of the next address. The memory model acknowledges after a random wait of zero to two cycles, so zero-wait handoffs happen often. Each handoff is judged twice. The memory contents must show the stored word. The next scan must return the word that the read-ahead fetched from the incremented address, with the write and read counters each advanced by exactly one.

// File: rtl/jwb_pkg.sv
package jwb_pkg;

    localparam int AW   = 29;
    localparam int DW   = 64;
    localparam int IRW  = 4;
    localparam int SELW = DW / 8;

    typedef logic [AW-1:0] addr_t;
    typedef logic [DW-1:0] word_t;

    typedef enum logic [IRW-1:0] {
        IR_ADDR = 4'd5,
        IR_READ = 4'd6,
        IR_SWAP = 4'd7
    } ir_code_t;

    typedef struct packed {
        logic  wr;
        addr_t adr;
        word_t dat;
    } req_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WR   = 2'd1,
        ST_RD   = 2'd2
    } bus_st_t;

    function automatic logic is_data_code(input logic [IRW-1:0] code);
        return (code == IR_READ) || (code == IR_SWAP);
    endfunction

endpackage

// File: rtl/jwb_sync.sv
module jwb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] ff;

    always_ff @(posedge clk) begin
        if (rst) ff <= '0;
        else     ff <= {ff[STAGES-2:0], d};
    end

    assign q = ff[STAGES-1];
endmodule

// File: rtl/jwb_tck_regs.sv
module jwb_tck_regs
    import jwb_pkg::*;
(
    input  logic           tck,
    input  logic           tck_rst,
    input  logic [IRW-1:0] ir,
    input  logic           capture_dr,
    input  logic           shift_dr,
    input  logic           update_dr,
    input  logic           tdi,
    output logic           tdo,
    input  word_t          rd_word,
    input  logic           ack_tgl_s,
    output req_t           req_o,
    output logic           req_tgl_o
);
    word_t sr;
    addr_t addr_q;
    req_t  req_q;
    logic  req_tgl;
    logic  sel_addr, sel_data;

    assign sel_addr = (ir == IR_ADDR);
    assign sel_data = is_data_code(ir);

    always_ff @(posedge tck) begin
        if (tck_rst) begin
            sr      <= '0;
            addr_q  <= '0;
            req_q   <= '0;
            req_tgl <= 1'b0;
        end else if (capture_dr) begin
            if (sel_addr)      sr <= {{(DW-AW){1'b0}}, addr_q};
            else if (sel_data) sr <= rd_word;
        end else if (shift_dr) begin
            if (sel_addr)      sr <= {{(DW-AW){1'b0}}, tdi, sr[AW-1:1]};
            else if (sel_data) sr <= {tdi, sr[DW-1:1]};
        end else if (update_dr) begin
            if (sel_addr) begin
                addr_q    <= sr[AW-1:0];
                req_q.wr  <= 1'b0;
                req_q.adr <= sr[AW-1:0];
                req_q.dat <= '0;
                req_tgl   <= ~req_tgl;
            end else if (ir == IR_READ) begin
                addr_q    <= addr_q + 1'b1;
                req_q.wr  <= 1'b0;
                req_q.adr <= addr_q + 1'b1;
                req_q.dat <= '0;
                req_tgl   <= ~req_tgl;
            end else if (ir == IR_SWAP) begin
                addr_q    <= addr_q + 1'b1;
                req_q.wr  <= 1'b1;
                req_q.adr <= addr_q;
                req_q.dat <= sr;
                req_tgl   <= ~req_tgl;
            end
        end
    end

    assign tdo       = sr[0];
    assign req_o     = req_q;
    assign req_tgl_o = req_tgl;

    AST_ADDR_STEP: assert property (@(posedge tck) disable iff (tck_rst)
        update_dr && !capture_dr && !shift_dr && is_data_code(ir)
        |=> addr_q == $past(addr_q) + 1'b1);                          // R6

    AST_REQ_ON_UPDATE: assert property (@(posedge tck) disable iff (tck_rst)
        (req_tgl != $past(req_tgl)) |-> $past(update_dr));            // R8

    AST_SWAP_OLD_ADDR: assert property (@(posedge tck) disable iff (tck_rst)
        update_dr && !capture_dr && !shift_dr && (ir == IR_SWAP)
        |=> req_q.wr && (req_q.adr == $past(addr_q)));                 // R5

    AST_UPDATE_WHEN_IDLE: assert property (@(posedge tck) disable iff (tck_rst)
        update_dr && (sel_addr || sel_data) |-> (req_tgl == ack_tgl_s)); // R8
endmodule

// File: rtl/jwb_sys_master.sv
module jwb_sys_master
    import jwb_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            req_tgl_s,
    input  req_t            req_i,
    output logic            ack_tgl_o,
    output word_t           rd_word_o,
    output logic            wb_cyc,
    output logic            wb_stb,
    output logic            wb_we,
    output addr_t           wb_adr,
    output word_t           wb_dat_o,
    output logic [SELW-1:0] wb_sel,
    input  word_t           wb_dat_i,
    input  logic            wb_ack
);
    bus_st_t st;
    addr_t   adr_q;
    word_t   dat_q;
    word_t   rd_word;
    logic    seen;
    logic    ack_tgl;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            adr_q   <= '0;
            dat_q   <= '0;
            rd_word <= '0;
            seen    <= 1'b0;
            ack_tgl <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: if (req_tgl_s != seen) begin
                    seen  <= req_tgl_s;
                    adr_q <= req_i.adr;
                    dat_q <= req_i.dat;
                    st    <= req_i.wr ? ST_WR : ST_RD;
                end
                ST_WR: if (wb_ack) begin
                    adr_q <= adr_q + 1'b1;
                    st    <= ST_RD;
                end
                ST_RD: if (wb_ack) begin
                    rd_word <= wb_dat_i;
                    ack_tgl <= ~ack_tgl;
                    st      <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign wb_cyc    = (st != ST_IDLE);
    assign wb_stb    = (st != ST_IDLE);
    assign wb_we     = (st == ST_WR);
    assign wb_adr    = adr_q;
    assign wb_dat_o  = dat_q;
    assign wb_sel    = '1;
    assign ack_tgl_o = ack_tgl;
    assign rd_word_o = rd_word;

    AST_CYCLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        wb_cyc && !wb_ack |=> wb_cyc && $stable(wb_adr) && $stable(wb_we)
                              && $stable(wb_dat_o));                    // R7

    AST_READ_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        wb_cyc && wb_we && wb_ack
        |=> wb_cyc && !wb_we && (wb_adr == $past(wb_adr) + 1'b1));     // R5
endmodule

// File: rtl/jwb_bridge.sv
module jwb_bridge
    import jwb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tck,
    input  logic            tck_rst,
    input  logic [IRW-1:0]  ir,
    input  logic            capture_dr,
    input  logic            shift_dr,
    input  logic            update_dr,
    input  logic            tdi,
    output logic            tdo,
    output logic            wb_cyc,
    output logic            wb_stb,
    output logic            wb_we,
    output logic [AW-1:0]   wb_adr,
    output logic [DW-1:0]   wb_dat_o,
    output logic [SELW-1:0] wb_sel,
    input  logic [DW-1:0]   wb_dat_i,
    input  logic            wb_ack
);
    req_t  req;
    logic  req_tgl, req_tgl_s;
    logic  ack_tgl, ack_tgl_s;
    word_t rd_word;

    jwb_tck_regs u_tck (
        .tck        (tck),
        .tck_rst    (tck_rst),
        .ir         (ir),
        .capture_dr (capture_dr),
        .shift_dr   (shift_dr),
        .update_dr  (update_dr),
        .tdi        (tdi),
        .tdo        (tdo),
        .rd_word    (rd_word),
        .ack_tgl_s  (ack_tgl_s),
        .req_o      (req),
        .req_tgl_o  (req_tgl)
    );

    jwb_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk (clk), .rst (rst), .d (req_tgl), .q (req_tgl_s)
    );

    jwb_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk (tck), .rst (tck_rst), .d (ack_tgl), .q (ack_tgl_s)
    );

    jwb_sys_master u_sys (
        .clk       (clk),
        .rst       (rst),
        .req_tgl_s (req_tgl_s),
        .req_i     (req),
        .ack_tgl_o (ack_tgl),
        .rd_word_o (rd_word),
        .wb_cyc    (wb_cyc),
        .wb_stb    (wb_stb),
        .wb_we     (wb_we),
        .wb_adr    (wb_adr),
        .wb_dat_o  (wb_dat_o),
        .wb_sel    (wb_sel),
        .wb_dat_i  (wb_dat_i),
        .wb_ack    (wb_ack)
    );
endmodule

// File: tb/jwb_bridge_tb.sv
`timescale 1ns/1ps
module jwb_bridge_tb;
    logic        clk = 0, tck = 0;
    logic        rst, tck_rst;
    logic [3:0]  ir = 4'd0;
    logic        capture_dr = 0, shift_dr = 0, update_dr = 0, tdi = 0;
    logic        tdo;
    logic        wb_cyc, wb_stb, wb_we, wb_ack;
    logic [28:0] wb_adr;
    logic [63:0] wb_dat_o, wb_dat_i;
    logic [7:0]  wb_sel;

    always #4  clk = ~clk;
    always #40 tck = ~tck;

    jwb_bridge u_dut (
        .clk(clk), .rst(rst), .tck(tck), .tck_rst(tck_rst), .ir(ir),
        .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
        .tdi(tdi), .tdo(tdo), .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we),
        .wb_adr(wb_adr), .wb_dat_o(wb_dat_o), .wb_sel(wb_sel),
        .wb_dat_i(wb_dat_i), .wb_ack(wb_ack)
    );

    function automatic logic [63:0] init_word(input int i);
        return {32'hA500_0000 + 32'(i), ~(32'h0000_1000 + 32'(i * 7))};
    endfunction

    // memory model
    logic [63:0] mem [0:31];
    logic [63:0] rd_dat;
    logic [28:0] last_rd, last_wr;
    int n_rd, n_wr, wait_cnt, sel_bad, drop_bad;
    logic prev_cyc, prev_ack;
    assign wb_dat_i = rd_dat;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 32; i++) mem[i] <= init_word(i);
            wb_ack <= 0; rd_dat <= '0; n_rd <= 0; n_wr <= 0; wait_cnt <= 0;
            sel_bad <= 0; drop_bad <= 0; prev_cyc <= 0; prev_ack <= 0;
            last_rd <= '0; last_wr <= '0;
        end else begin
            wb_ack <= 1'b0;
            if (wb_cyc && wb_stb && !wb_ack) begin
                if (wb_sel != 8'hFF) sel_bad <= sel_bad + 1;
                if (wait_cnt == 0) begin
                    wb_ack   <= 1'b1;
                    wait_cnt <= int'($urandom_range(0, 2));
                    if (wb_we) begin
                        mem[wb_adr[4:0]] <= wb_dat_o; n_wr <= n_wr + 1; last_wr <= wb_adr;
                    end else begin
                        rd_dat <= mem[wb_adr[4:0]]; n_rd <= n_rd + 1; last_rd <= wb_adr;
                    end
                end else wait_cnt <= wait_cnt - 1;
            end
            if (prev_cyc && !prev_ack && !wb_cyc) drop_bad <= drop_bad + 1;
            if (wb_cyc != wb_stb) drop_bad <= drop_bad + 1;
            prev_cyc <= wb_cyc;
            prev_ack <= wb_ack;
        end
    end

    int checks = 0, errors = 0;
    bit done = 0;
    logic [63:0] ref_mem [0:31];
    logic [28:0] ref_addr;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic dr_scan(input logic [3:0] code, input logic [63:0] din,
                           input int nbits, output logic [63:0] dout);
        dout = '0;
        @(negedge tck); ir = code; capture_dr = 1;
        for (int k = 0; k < nbits; k++) begin
            @(negedge tck); capture_dr = 0; shift_dr = 1;
            dout[k] = tdo; tdi = din[k];
        end
        @(negedge tck); shift_dr = 0; update_dr = 1;
        @(negedge tck); update_dr = 0;
        repeat (6) @(negedge tck);
    endtask

    task automatic op_addr(input logic [28:0] a);
        logic [63:0] d; int r0, w0;
        r0 = n_rd; w0 = n_wr;
        dr_scan(4'd5, {35'd0, a}, 29, d);
        chk("R2 captured address", {35'd0, d[28:0]}, {35'd0, ref_addr});
        ref_addr = a;
        chk("R3 one read after address load", 64'(n_rd - r0), 64'd1);
        chk("R3 no write after address load", 64'(n_wr - w0), 64'd0);
        chk("R3 read address", {35'd0, last_rd}, {35'd0, a});
    endtask

    task automatic op_read();
        logic [63:0] d; int r0, w0;
        r0 = n_rd; w0 = n_wr;
        dr_scan(4'd6, {$urandom, $urandom}, 64, d);
        chk("R4 read word", d, ref_mem[ref_addr[4:0]]);
        chk("R4 no write on read", 64'(n_wr - w0), 64'd0);
        chk("R8 one read per read update", 64'(n_rd - r0), 64'd1);
        ref_addr = ref_addr + 1'b1;
        chk("R6 read-ahead at next address", {35'd0, last_rd}, {35'd0, ref_addr});
    endtask

    task automatic op_swap(input logic [63:0] w);
        logic [63:0] d; int r0, w0;
        r0 = n_rd; w0 = n_wr;
        dr_scan(4'd7, w, 64, d);
        chk("R5 old word returned", d, ref_mem[ref_addr[4:0]]);
        chk("R8 one write per swap", 64'(n_wr - w0), 64'd1);
        chk("R8 one read per swap", 64'(n_rd - r0), 64'd1);
        chk("R5 write address", {35'd0, last_wr}, {35'd0, ref_addr});
        chk("R5 stored word", mem[ref_addr[4:0]], w);
        ref_mem[ref_addr[4:0]] = w;
        ref_addr = ref_addr + 1'b1;
        chk("R6 read-ahead after swap", {35'd0, last_rd}, {35'd0, ref_addr});
    endtask

    initial begin
        #(8 * 190000);
        if (!done) begin
            errors++;
            $display("FAIL R8 watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] d;
        int r0, w0;
        void'($urandom(32'd1234));
        for (int i = 0; i < 32; i++) ref_mem[i] = init_word(i);
        ref_addr = '0;
        rst = 1; tck_rst = 1;
        repeat (4) @(negedge tck);
        rst = 0; tck_rst = 0;
        @(negedge tck);
        chk("R9 tdo after reset", {63'd0, tdo}, 64'd0);
        chk("R9 no cycle after reset", {63'd0, wb_cyc}, 64'd0);

        op_addr(29'd3);                 // R9: captured value is reset address 0
        op_swap(64'h1111_2222_3333_4444);
        op_swap(64'h5555_6666_7777_8888);
        op_addr(29'd3);                 // R2/R6: captured 5
        op_read();
        op_read();

        // R1: foreign codes do nothing
        r0 = n_rd; w0 = n_wr;
        dr_scan(4'd9, 64'hFFFF_FFFF_FFFF_FFFF, 64, d);
        dr_scan(4'd0, 64'h0, 29, d);
        chk("R1 no read on foreign code", 64'(n_rd - r0), 64'd0);
        chk("R1 no write on foreign code", 64'(n_wr - w0), 64'd0);
        op_addr(ref_addr);              // R1: captured address unchanged

        // R6 wrap
        op_addr(29'h1FFF_FFFF);
        op_swap(64'hDEAD_BEEF_0BAD_F00D);
        chk("R6 wrapped address", {35'd0, ref_addr}, 64'd0);
        op_read();

        for (int it = 0; it < 40; it++) begin
            int sel;
            sel = int'($urandom_range(0, 4));
            if (sel == 0)      op_addr({24'd0, 5'($urandom)});
            else if (sel == 1) op_read();
            else               op_swap({$urandom, $urandom});
        end
        op_addr(ref_addr);

        chk("R7 cycle held until ack, cyc equals stb", 64'(drop_bad), 64'd0);
        chk("R5 byte selects all ones", 64'(sel_bad), 64'd0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule